// File: doc/BRIEF.md
# Triggered Trace Capture Controller

This controller sits beside a processor core and writes one trace entry into a circular trace memory for every valid processor cycle. An external comparator supplies a one-cycle trigger pulse. The controller records where in memory the trigger landed. It then decides, according to its configuration, when capture ends and whether the processor is asked to halt.

Four end-of-capture policies are selectable. The controller can halt at the trigger itself. It can keep tracing for a programmed number of post-trigger cycles and then halt. It can trace the same post-trigger window without ever halting. Or it can fill the memory once, without wrapping, and halt when the memory is full.

A filter option removes forced-NOP cycles from event processing. A forced-NOP cycle is the discarded second cycle of a two-cycle, program-counter-changing instruction. When the filter is on, these cycles are still recorded, but they cannot trigger and they do not count toward the post-trigger window. A synchronous arm input restarts a capture from a clean state.

Top module: `trc_capture_ctrl`

## Requirements
- R1: After `rst` or a cycle with `arm` high, the outputs are cleared: `halt_req`=0, `capture_done`=0, `trig_valid`=0, `entry_count`=0 and `mem_addr`=0. Nothing is written in the `arm` cycle itself.
- R2: While capture is active, every cycle with `cyc_valid`=1 asserts `mem_we` in that same cycle, with `mem_addr` equal to the current pointer and `mem_wdata` equal to `cyc_data`. The pointer then advances by one. In modes 0 to 2 the pointer wraps from 65535 to 0.
- R3: `entry_count` rises by one per write and saturates at 65535.
- R4: The first qualified trigger after arming is accepted. `trig_index` latches the address of the entry written in that cycle, and `trig_valid` goes high. Later trigger pulses change nothing.
- R5: Mode 2'b01 (halt at trigger): the trigger cycle's entry is the last entry written. `halt_req` and `capture_done` are high from the next cycle on.
- R6: Mode 2'b10 (halt after window): after the trigger entry, exactly `cfg_post_len` further counted cycles are written. Then `halt_req` and `capture_done` rise. A length of 0 ends capture at the trigger entry.
- R7: Mode 2'b00 (no halt): the capture window is the same as in R6, and `capture_done` rises at the end of it, but `halt_req` stays 0.
- R8: Mode 2'b11 (stop when full): the pointer never wraps. The write that brings `entry_count` to 65535 is the last one, and `halt_req` and `capture_done` rise after it. A trigger is still recorded, but it does not end capture.
- R9: With `cfg_skip_fnop`=1, a cycle with `cyc_fnop`=1 is written but neither triggers nor counts toward the window. With `cfg_skip_fnop`=0, such a cycle triggers and counts like any other.
- R10: Once `capture_done` is high, `mem_we` stays 0 until the next arm or reset.
- R11: A cycle with `cyc_valid`=0 writes nothing, counts nothing and cannot trigger.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| arm | input | 1 | Synchronous restart of capture |
| cfg_mode | input | 2 | End policy: 0 no halt, 1 halt at trigger, 2 halt after window, 3 stop when full |
| cfg_post_len | input | 16 | Number of counted cycles written after the trigger |
| cfg_skip_fnop | input | 1 | Exclude forced-NOP cycles from triggering and counting |
| cyc_valid | input | 1 | A processor cycle is present |
| cyc_data | input | 32 | Trace word for this cycle |
| cyc_trig | input | 1 | Trigger pulse from the comparator |
| cyc_fnop | input | 1 | This cycle is a forced NOP |
| mem_we | output | 1 | Trace memory write enable |
| mem_addr | output | 16 | Trace memory write address |
| mem_wdata | output | 32 | Trace memory write data |
| halt_req | output | 1 | Request to halt the processor |
| capture_done | output | 1 | Capture has ended |
| trig_valid | output | 1 | A trigger has been accepted |
| trig_index | output | 16 | Address of the trigger entry |
| entry_count | output | 16 | Saturating count of written entries |

## Verification
A mixed cycle pattern interleaves idle cycles, filtered forced-NOP cycles carrying a trigger, and a second late trigger. It shows whether filtered cycles are recorded but neither trigger nor count, and whether only the first trigger is kept. Short directed runs in each mode compare where the last write falls and whether a halt follows. A run with a zero-length window checks the boundary of R6. A run with filtering off shows forced-NOP cycles triggering and counting. Two long runs of more than 65535 cycles separate the behaviour of the circular modes, where the pointer wraps and the count saturates, from the stop-when-full mode, where writing ends at exactly 65535 entries.

// File: rtl/trc_pkg.sv
package trc_pkg;

    typedef enum logic [1:0] {
        HM_NONE     = 2'b00,
        HM_ON_TRIG  = 2'b01,
        HM_AFTER    = 2'b10,
        HM_ON_FULL  = 2'b11
    } halt_mode_e;

    typedef enum logic [1:0] {
        PH_PRE  = 2'b00,
        PH_POST = 2'b01,
        PH_STOP = 2'b10
    } phase_e;

    // Qualified view of one processor cycle
    typedef struct packed {
        logic live;    // cycle present, will be recorded
        logic counts;  // cycle takes part in event processing
        logic trig;    // qualified trigger
    } cyc_ev_t;

    function automatic int unsigned entry_limit(input int unsigned aw);
        return (1 << aw) - 1;
    endfunction

endpackage

// File: rtl/trc_qualify.sv
module trc_qualify
    import trc_pkg::*;
(
    input  logic    cyc_valid,
    input  logic    cyc_trig,
    input  logic    cyc_fnop,
    input  logic    skip_fnop,
    output cyc_ev_t ev
);
    always_comb begin
        ev.live   = cyc_valid;
        ev.counts = cyc_valid && !(skip_fnop && cyc_fnop);
        ev.trig   = ev.counts && cyc_trig;
    end
endmodule

// File: rtl/trc_wrptr.sv
module trc_wrptr #(
    parameter int unsigned ADDR_W = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              clr,
    input  logic              adv,
    output logic [ADDR_W-1:0] ptr,
    output logic [ADDR_W-1:0] count
);
    localparam logic [ADDR_W-1:0] LIMIT = ADDR_W'(trc_pkg::entry_limit(ADDR_W));

    always_ff @(posedge clk) begin
        if (rst || clr) begin
            ptr   <= '0;
            count <= '0;
        end else if (adv) begin
            ptr <= ptr + 1'b1;
            if (count != LIMIT)
                count <= count + 1'b1;
        end
    end

    assert_ptr_step_R2: assert property (@(posedge clk) disable iff (rst)
        (adv && !clr) |=> (ptr == ADDR_W'($past(ptr) + 1'b1)));

    assert_count_saturates_R3: assert property (@(posedge clk) disable iff (rst)
        (adv && !clr && count == LIMIT) |=> (count == LIMIT));

    assert_clear_state_R1: assert property (@(posedge clk) disable iff (rst)
        clr |=> (ptr == '0 && count == '0));
endmodule

// File: rtl/trc_sequencer.sv
module trc_sequencer
    import trc_pkg::*;
#(
    parameter int unsigned ADDR_W = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              clr,
    input  cyc_ev_t           ev,
    input  halt_mode_e        mode,
    input  logic [ADDR_W-1:0] post_len,
    input  logic [ADDR_W-1:0] ptr,
    input  logic [ADDR_W-1:0] count,
    output logic              mem_we,
    output logic              halt_req,
    output logic              done,
    output logic              trig_valid,
    output logic [ADDR_W-1:0] trig_index
);
    localparam logic [ADDR_W-1:0] LIMIT    = ADDR_W'(entry_limit(ADDR_W));
    localparam logic [ADDR_W-1:0] LIMIT_M1 = LIMIT - 1'b1;

    phase_e            phase;
    logic [ADDR_W-1:0] post_cnt;
    logic [ADDR_W-1:0] post_next;
    logic              capturing;
    logic              full_block;
    logic              accept;
    logic              win_step;
    logic              finish;

    always_comb begin
        capturing  = (phase != PH_STOP);
        full_block = (mode == HM_ON_FULL) && (count == LIMIT);
        mem_we     = !clr && capturing && ev.live && !full_block;
        accept     = !clr && (phase == PH_PRE) && ev.trig;
        post_next  = post_cnt + 1'b1;
        win_step   = !clr && (phase == PH_POST) && ev.counts;
        unique case (mode)
            HM_ON_TRIG: finish = accept;
            HM_ON_FULL: finish = mem_we && (count == LIMIT_M1);
            default:    finish = (accept && post_len == '0) ||
                                 (win_step && post_next == post_len);
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst || clr) begin
            phase      <= PH_PRE;
            post_cnt   <= '0;
            halt_req   <= 1'b0;
            done       <= 1'b0;
            trig_valid <= 1'b0;
            trig_index <= '0;
        end else begin
            if (finish) begin
                phase    <= PH_STOP;
                done     <= 1'b1;
                halt_req <= (mode != HM_NONE);
            end else if (accept) begin
                phase <= PH_POST;
            end
            if (accept) begin
                trig_valid <= 1'b1;
                trig_index <= ptr;
            end
            if (win_step)
                post_cnt <= post_next;
        end
    end

    assert_quiet_after_done_R10: assert property (@(posedge clk) disable iff (rst)
        done |-> !mem_we);

    assert_halt_needs_done_R5: assert property (@(posedge clk) disable iff (rst)
        halt_req |-> done);

    assert_trig_index_held_R4: assert property (@(posedge clk) disable iff (rst)
        (trig_valid && !clr) |=> ($stable(trig_index) && trig_valid));

    assert_done_sticky_R10: assert property (@(posedge clk) disable iff (rst)
        (done && !clr) |=> done);
endmodule

// File: rtl/trc_capture_ctrl.sv
module trc_capture_ctrl
    import trc_pkg::*;
#(
    parameter int unsigned ADDR_W = 16,
    parameter int unsigned DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              arm,
    input  logic [1:0]        cfg_mode,
    input  logic [ADDR_W-1:0] cfg_post_len,
    input  logic              cfg_skip_fnop,
    input  logic              cyc_valid,
    input  logic [DATA_W-1:0] cyc_data,
    input  logic              cyc_trig,
    input  logic              cyc_fnop,
    output logic              mem_we,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [DATA_W-1:0] mem_wdata,
    output logic              halt_req,
    output logic              capture_done,
    output logic              trig_valid,
    output logic [ADDR_W-1:0] trig_index,
    output logic [ADDR_W-1:0] entry_count
);
    cyc_ev_t           ev;
    logic [ADDR_W-1:0] ptr;
    halt_mode_e        mode;

    assign mode      = halt_mode_e'(cfg_mode);
    assign mem_addr  = ptr;
    assign mem_wdata = cyc_data;

    trc_qualify u_qual (
        .cyc_valid (cyc_valid),
        .cyc_trig  (cyc_trig),
        .cyc_fnop  (cyc_fnop),
        .skip_fnop (cfg_skip_fnop),
        .ev        (ev)
    );

    trc_wrptr #(.ADDR_W(ADDR_W)) u_ptr (
        .clk   (clk),
        .rst   (rst),
        .clr   (arm),
        .adv   (mem_we),
        .ptr   (ptr),
        .count (entry_count)
    );

    trc_sequencer #(.ADDR_W(ADDR_W)) u_seq (
        .clk        (clk),
        .rst        (rst),
        .clr        (arm),
        .ev         (ev),
        .mode       (mode),
        .post_len   (cfg_post_len),
        .ptr        (ptr),
        .count      (entry_count),
        .mem_we     (mem_we),
        .halt_req   (halt_req),
        .done       (capture_done),
        .trig_valid (trig_valid),
        .trig_index (trig_index)
    );

    assert_no_write_invalid_R11: assert property (@(posedge clk) disable iff (rst)
        !cyc_valid |-> !mem_we);
endmodule

// File: tb/tb_trc_capture_ctrl.sv
module tb_trc_capture_ctrl;
    logic        clk = 1'b0;
    logic        rst, arm, cfg_skip_fnop, cyc_valid, cyc_trig, cyc_fnop;
    logic [1:0]  cfg_mode;
    logic [15:0] cfg_post_len;
    logic [31:0] cyc_data;
    logic        mem_we, halt_req, capture_done, trig_valid;
    logic [15:0] mem_addr, trig_index, entry_count;
    logic [31:0] mem_wdata;

    int checks = 0;
    int errors = 0;

    always #10 clk = ~clk;

    trc_capture_ctrl dut (
        .clk(clk), .rst(rst), .arm(arm), .cfg_mode(cfg_mode),
        .cfg_post_len(cfg_post_len), .cfg_skip_fnop(cfg_skip_fnop),
        .cyc_valid(cyc_valid), .cyc_data(cyc_data), .cyc_trig(cyc_trig),
        .cyc_fnop(cyc_fnop), .mem_we(mem_we), .mem_addr(mem_addr),
        .mem_wdata(mem_wdata), .halt_req(halt_req), .capture_done(capture_done),
        .trig_valid(trig_valid), .trig_index(trig_index), .entry_count(entry_count)
    );

    typedef struct packed {
        logic        arm;
        logic        valid;
        logic        trig;
        logic        fnop;
        logic        e_we;
        logic        e_done;
        logic [15:0] e_addr;
    } vec_t;

    // mode 0, window 2, forced-NOP filter on
    localparam vec_t VEC [10] = '{
        '{1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 16'd0},
        '{1'b0, 1'b1, 1'b0, 1'b0, 1'b1, 1'b0, 16'd0},
        '{1'b0, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0, 16'd1},
        '{1'b0, 1'b1, 1'b1, 1'b1, 1'b1, 1'b0, 16'd1},
        '{1'b0, 1'b1, 1'b1, 1'b0, 1'b1, 1'b0, 16'd2},
        '{1'b0, 1'b1, 1'b0, 1'b1, 1'b1, 1'b0, 16'd3},
        '{1'b0, 1'b1, 1'b1, 1'b0, 1'b1, 1'b0, 16'd4},
        '{1'b0, 1'b1, 1'b0, 1'b0, 1'b1, 1'b0, 16'd5},
        '{1'b0, 1'b1, 1'b0, 1'b0, 1'b0, 1'b1, 16'd6},
        '{1'b0, 1'b1, 1'b0, 1'b0, 1'b0, 1'b1, 16'd6}
    };

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    // Drive one cycle's inputs after the falling edge; sample before the rising edge
    task automatic step(input logic a, input logic v, input logic t, input logic f);
        @(negedge clk);
        arm = a; cyc_valid = v; cyc_trig = t; cyc_fnop = f;
        cyc_data = 32'hA500_0000 ^ 32'(checks);
        #5;
    endtask

    task automatic finish_run();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        rst = 1'b1; arm = 1'b0; cyc_valid = 1'b0; cyc_trig = 1'b0; cyc_fnop = 1'b0;
        cyc_data = '0; cfg_mode = 2'b00; cfg_post_len = 16'd2; cfg_skip_fnop = 1'b1;
        repeat (3) @(posedge clk);
        @(negedge clk); rst = 1'b0; #5;

        // R1 reset state
        check("R1 halt", 32'(halt_req), 0);
        check("R1 done", 32'(capture_done), 0);
        check("R1 count", 32'(entry_count), 0);
        check("R1 addr", 32'(mem_addr), 0);
        check("R1 trig_valid", 32'(trig_valid), 0);

        // Table walk: R2, R4, R7, R9, R11
        foreach (VEC[i]) begin
            step(VEC[i].arm, VEC[i].valid, VEC[i].trig, VEC[i].fnop);
            check("R2/R11 we", 32'(mem_we), 32'(VEC[i].e_we));
            check("R2 addr", 32'(mem_addr), 32'(VEC[i].e_addr));
            check("R7 done", 32'(capture_done), 32'(VEC[i].e_done));
            if (VEC[i].e_we) check("R2 data", mem_wdata, cyc_data);
        end
        check("R4 trig index", 32'(trig_index), 2);
        check("R9 filtered trigger ignored, count", 32'(entry_count), 6);
        check("R7 no halt", 32'(halt_req), 0);

        // R5 halt at trigger
        cfg_mode = 2'b01;
        step(1, 0, 0, 0);
        check("R1 arm no write", 32'(mem_we), 0);
        step(0, 1, 0, 0);
        check("R1 cleared count", 32'(entry_count), 0);
        check("R1 cleared done", 32'(capture_done), 0);
        step(0, 1, 0, 0);
        step(0, 1, 1, 0);
        check("R5 trigger written", 32'(mem_we), 1);
        check("R5 trigger addr", 32'(mem_addr), 2);
        step(0, 1, 0, 0);
        check("R5 halt", 32'(halt_req), 1);
        check("R10 no write", 32'(mem_we), 0);
        check("R5 count", 32'(entry_count), 3);
        check("R4 index", 32'(trig_index), 2);

        // R6 zero window, R9 unfiltered forced-NOP triggers
        cfg_mode = 2'b10; cfg_post_len = 16'd0; cfg_skip_fnop = 1'b0;
        step(1, 0, 0, 0);
        step(0, 1, 1, 1);
        check("R9 fnop trigger written", 32'(mem_we), 1);
        step(0, 1, 0, 0);
        check("R6 zero window halt", 32'(halt_req), 1);
        check("R6 zero window count", 32'(entry_count), 1);
        check("R9 fnop trigger accepted", 32'(trig_valid), 1);

        // R6 window of 3, forced-NOPs counted (R9)
        cfg_post_len = 16'd3;
        step(1, 0, 0, 0);
        step(0, 1, 0, 0);
        step(0, 1, 1, 0);
        step(0, 1, 0, 1);
        step(0, 1, 0, 1);
        step(0, 1, 0, 1);
        check("R6 last window write", 32'(mem_we), 1);
        check("R6 not yet halted", 32'(halt_req), 0);
        step(0, 1, 0, 0);
        check("R6 halt after window", 32'(halt_req), 1);
        check("R6 count", 32'(entry_count), 5);
        check("R10 no write", 32'(mem_we), 0);

        // R2/R3 wrap in circular mode, no trigger
        cfg_mode = 2'b00;
        step(1, 0, 0, 0);
        begin
            int bad = 0;
            for (int i = 0; i < 65536; i++) begin
                step(0, 1, 0, 0);
                if (mem_we !== 1'b1 || mem_addr !== 16'(i)) bad++;
            end
            check("R2 sequential addresses", 32'(bad), 0);
        end
        step(0, 1, 0, 0);
        check("R2 wrap to zero", 32'(mem_addr), 0);
        check("R2 write after wrap", 32'(mem_we), 1);
        check("R3 saturated count", 32'(entry_count), 65535);

        // R8 stop when full
        cfg_mode = 2'b11;
        step(1, 0, 0, 0);
        begin
            int bad = 0;
            for (int i = 0; i < 65535; i++) begin
                step(0, 1, (i == 10), 0);
                if (mem_we !== 1'b1 || mem_addr !== 16'(i)) bad++;
            end
            check("R8 writes until full", 32'(bad), 0);
        end
        check("R8 trigger did not stop capture", 32'(capture_done), 0);
        step(0, 1, 0, 0);
        check("R8 no write when full", 32'(mem_we), 0);
        check("R8 halt when full", 32'(halt_req), 1);
        check("R8 count", 32'(entry_count), 65535);
        check("R8 trig index", 32'(trig_index), 10);

        finish_run();
    end
endmodule